// File: doc/BRIEF.md
# NAND Bus Strobe Sequencer

This block converts one bus request at a time (a command byte, an address byte, a data byte to write, or a data byte to read) into the strobe waveform seen by a raw 8-bit NAND flash device. Every phase of the waveform is measured in controller clock cycles. The lengths are unpacked from a single 26-bit timing word that comes with the request. The block drives chip enable, the write and read strobes, the command and address latch enables, and the output enable of the shared data bus. It samples the device's ready/busy line and reports completion with a one-cycle done pulse. Read data is returned on a holding register.

A surrounding controller issues requests back to back. It sets the "last" flag on the final write of a command sequence so that the block waits for the device to finish its internal operation. The block remembers whether the previous access was a read, and puts a bus turnaround gap in front of the next access that drives the bus.

Top module: `nand_strobe_gen`

## Requirements
- R1: After reset, chip enable, write strobe and read strobe are high (inactive), the latch enables, the bus output enable and done are low.
- R2: A request is accepted only in an idle cycle with req_valid high. From the next cycle until the done cycle, chip enable is low, beginning with a setup phase of timing-word bits 25:24 cycles in which both strobes stay high.
- R3: req_kind encodes 0 = command, 1 = address, 2 = data write, 3 = data read. For kinds 0 to 2 the write strobe is low for bits 3:0 cycles and then high for bits 7:4 cycles. The bus output enable is high and nand_dq_out carries the request byte during both of these phases.
- R4: For kind 3 the read strobe is low for bits 11:8 cycles and then high for bits 15:12 cycles, and the bus output enable stays low throughout.
- R5: A timing field whose value is zero gives a phase of one cycle.
- R6: A read captures nand_dq_in at the clock edge where the read strobe returns high. rd_byte holds that value until the next read.
- R7: When a request of kind 0 to 2 follows a read, a turnaround phase of bits 18:16 cycles is placed between the setup phase and the strobe-low phase. During it the strobes are high and the output enable is low.
- R8: A request of kind 0 to 2 with req_last high continues after its strobe-high phase with a busy delay of bits 23:19 cycles, during which nand_rb is ignored. It then waits until nand_rb is sampled high. Chip enable stays low and the latch enables stay low during both of these phases.
- R9: done is high for exactly one cycle, the cycle after the final phase, with chip enable already high. A request presented while the block is not idle has no effect.
- R10: The command latch enable is high from the setup phase through the strobe-high phase for kind 0 only. The address latch enable does the same for kind 1 only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_kind | input | 2 | Request kind (command, address, write, read) |
| req_last | input | 1 | Final write of a sequence; wait for ready |
| req_byte | input | 8 | Byte to drive on the bus |
| timing_word | input | 26 | Packed phase lengths |
| nand_ce_n | output | 1 | Chip enable, active low |
| nand_we_n | output | 1 | Write strobe, active low |
| nand_re_n | output | 1 | Read strobe, active low |
| nand_cmd_lat | output | 1 | Command latch enable |
| nand_addr_lat | output | 1 | Address latch enable |
| nand_dq_oe | output | 1 | Data bus output enable |
| nand_dq_out | output | 8 | Data bus value driven |
| nand_dq_in | input | 8 | Data bus value read |
| nand_rb | input | 1 | Device ready (high) / busy (low) |
| rd_byte | output | 8 | Last captured read byte |
| done | output | 1 | One-cycle completion pulse |

## Verification
Two functions can fall in the same cycle: the done pulse of one request and the acceptance of the next. The bench presents every new request during the done cycle of the previous one. It then compares the full strobe pattern of the new request cycle by cycle against a model built from the phase lengths. A second overlap is the read capture, which happens on the same edge that raises the read strobe. The bench changes nand_dq_in to a different value outside the strobe-low window, so a capture one cycle early or late returns the wrong byte.

// File: rtl/nsg_pkg.sv
package nsg_pkg;
  typedef enum logic [1:0] {
    K_CMD   = 2'd0,
    K_ADDR  = 2'd1,
    K_WDATA = 2'd2,
    K_RDATA = 2'd3
  } nsg_kind_e;

  typedef enum logic [2:0] {
    P_IDLE, P_SETUP, P_TURN, P_LOW, P_HIGH, P_BUSY, P_WAIT
  } nsg_phase_e;

  // field indices inside the packed timing word
  localparam int NFLD  = 7;
  localparam int F_WL  = 0;
  localparam int F_WH  = 1;
  localparam int F_RL  = 2;
  localparam int F_RH  = 3;
  localparam int F_TA  = 4;
  localparam int F_BSY = 5;
  localparam int F_CEA = 6;
  localparam int FLD_LSB [NFLD] = '{0, 4, 8, 12, 16, 19, 24};
  localparam int FLD_W   [NFLD] = '{4, 4, 4, 4, 3, 5, 2};
  localparam int TW_W  = 26;
  localparam int CNT_W = 5;
endpackage

// File: rtl/nsg_timing_decode.sv
module nsg_timing_decode
  import nsg_pkg::*;
(
  input  logic [TW_W-1:0]            word,
  output logic [NFLD-1:0][CNT_W-1:0] len
);
  for (genvar g = 0; g < NFLD; g++) begin : g_fld
    localparam int LSB = FLD_LSB[g];
    localparam int W   = FLD_W[g];
    logic [W-1:0] raw;
    assign raw    = word[LSB +: W];
    // a zero field still lasts one clock
    assign len[g] = (raw == '0) ? CNT_W'(1) : CNT_W'(raw);
  end
endmodule

// File: rtl/nsg_phase_timer.sv
module nsg_phase_timer #(
  parameter int W = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_len,
  output logic         expire
);
  logic [W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load)               cnt_d = load_len - 1'b1;
    else if (cnt_q != '0)   cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign expire = (cnt_q == '0);
endmodule

// File: rtl/nsg_seq_ctrl.sv
module nsg_seq_ctrl
  import nsg_pkg::*;
(
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       start,
  input  logic                       is_rd,
  input  logic                       wr_last,
  input  logic                       need_turn,
  input  logic                       expire,
  input  logic                       rb,
  input  logic [NFLD-1:0][CNT_W-1:0] len,
  output nsg_phase_e                 phase_q,
  output logic                       load,
  output logic [CNT_W-1:0]           load_len,
  output logic                       fin
);
  nsg_phase_e phase_d;
  logic [CNT_W-1:0] lo_len, hi_len;

  assign lo_len = is_rd ? len[F_RL] : len[F_WL];
  assign hi_len = is_rd ? len[F_RH] : len[F_WH];

  always_comb begin
    phase_d  = phase_q;
    load     = 1'b0;
    load_len = len[F_CEA];
    fin      = 1'b0;
    unique case (phase_q)
      P_IDLE: if (start) begin
        phase_d = P_SETUP; load = 1'b1; load_len = len[F_CEA];
      end
      P_SETUP: if (expire) begin
        load = 1'b1;
        if (need_turn) begin phase_d = P_TURN; load_len = len[F_TA]; end
        else           begin phase_d = P_LOW;  load_len = lo_len;    end
      end
      P_TURN: if (expire) begin
        phase_d = P_LOW; load = 1'b1; load_len = lo_len;
      end
      P_LOW: if (expire) begin
        phase_d = P_HIGH; load = 1'b1; load_len = hi_len;
      end
      P_HIGH: if (expire) begin
        if (wr_last) begin phase_d = P_BUSY; load = 1'b1; load_len = len[F_BSY]; end
        else         begin phase_d = P_IDLE; fin = 1'b1; end
      end
      P_BUSY: if (expire) phase_d = P_WAIT;
      P_WAIT: if (rb) begin phase_d = P_IDLE; fin = 1'b1; end
      default: phase_d = P_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= P_IDLE;
    else        phase_q <= phase_d;
  end
endmodule

// File: rtl/nand_strobe_gen.sv
module nand_strobe_gen
  import nsg_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [1:0]        req_kind,
  input  logic              req_last,
  input  logic [DATA_W-1:0] req_byte,
  input  logic [TW_W-1:0]   timing_word,
  output logic              nand_ce_n,
  output logic              nand_we_n,
  output logic              nand_re_n,
  output logic              nand_cmd_lat,
  output logic              nand_addr_lat,
  output logic              nand_dq_oe,
  output logic [DATA_W-1:0] nand_dq_out,
  input  logic [DATA_W-1:0] nand_dq_in,
  input  logic              nand_rb,
  output logic [DATA_W-1:0] rd_byte,
  output logic              done
);
  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_i_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_i_n = rst_sync_q[1];

  nsg_phase_e                 phase_q;
  nsg_kind_e                  kind_q;
  logic [DATA_W-1:0]          byte_q, rd_q;
  logic [TW_W-1:0]            tw_q, tw_sel;
  logic                       last_q, prev_rd_q, done_q;
  logic                       start, is_rd, load, expire, fin, cap, in_acc;
  logic [CNT_W-1:0]           load_len;
  logic [NFLD-1:0][CNT_W-1:0] len;

  assign start  = req_valid && (phase_q == P_IDLE);
  assign is_rd  = (kind_q == K_RDATA);
  assign tw_sel = (phase_q == P_IDLE) ? timing_word : tw_q;
  assign cap    = (phase_q == P_LOW) && expire && is_rd;

  nsg_timing_decode u_dec (.word(tw_sel), .len(len));

  nsg_phase_timer #(.W(CNT_W)) u_tmr (
    .clk(clk), .rst_n(rst_i_n), .load(load), .load_len(load_len), .expire(expire)
  );

  nsg_seq_ctrl u_seq (
    .clk(clk), .rst_n(rst_i_n), .start(start), .is_rd(is_rd),
    .wr_last(last_q && !is_rd), .need_turn(prev_rd_q && !is_rd),
    .expire(expire), .rb(nand_rb), .len(len), .phase_q(phase_q),
    .load(load), .load_len(load_len), .fin(fin)
  );

  // request holding registers, clock-enabled on acceptance
  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      kind_q <= K_CMD;
      byte_q <= '0;
      last_q <= 1'b0;
      tw_q   <= '0;
    end else if (start) begin
      kind_q <= nsg_kind_e'(req_kind);
      byte_q <= req_byte;
      last_q <= req_last;
      tw_q   <= timing_word;
    end
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n)  prev_rd_q <= 1'b0;
    else if (fin)  prev_rd_q <= is_rd;
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n)  rd_q <= '0;
    else if (cap)  rd_q <= nand_dq_in;
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) done_q <= 1'b0;
    else          done_q <= fin;
  end

  // pin decode from the phase register
  assign in_acc        = (phase_q == P_SETUP) || (phase_q == P_TURN) ||
                         (phase_q == P_LOW)   || (phase_q == P_HIGH);
  assign nand_ce_n     = (phase_q == P_IDLE);
  assign nand_we_n     = !((phase_q == P_LOW) && !is_rd);
  assign nand_re_n     = !((phase_q == P_LOW) && is_rd);
  assign nand_cmd_lat  = in_acc && (kind_q == K_CMD);
  assign nand_addr_lat = in_acc && (kind_q == K_ADDR);
  assign nand_dq_oe    = !is_rd && ((phase_q == P_LOW) || (phase_q == P_HIGH));
  assign nand_dq_out   = byte_q;
  assign rd_byte       = rd_q;
  assign done          = done_q;
endmodule

// File: rtl/nsg_checker.sv
module nsg_checker
  import nsg_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ce_n,
  input logic              we_n,
  input logic              re_n,
  input logic              cmd_lat,
  input logic              addr_lat,
  input logic              dq_oe,
  input logic              rb,
  input logic [DATA_W-1:0] dq_in,
  input logic [DATA_W-1:0] rd_byte,
  input logic              done,
  input nsg_phase_e        phase
);
  a_r3_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !(!we_n && !re_n));
  a_r4_no_drive_on_read: assert property (@(posedge clk) disable iff (!rst_n)
    !re_n |-> !dq_oe);
  a_r2_activity_needs_ce: assert property (@(posedge clk) disable iff (!rst_n)
    (!we_n || !re_n || dq_oe || cmd_lat || addr_lat) |-> !ce_n);
  a_r6_capture_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(re_n) |-> (rd_byte == $past(dq_in)));
  a_r8_wait_for_ready: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == P_WAIT && !rb) |=> !done);
  a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r9_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (ce_n && we_n && re_n && !dq_oe));
  a_r10_latch_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(cmd_lat && addr_lat));
endmodule

bind nand_strobe_gen nsg_checker #(.DATA_W(DATA_W)) u_nsg_checker (
  .clk(clk), .rst_n(rst_n), .ce_n(nand_ce_n), .we_n(nand_we_n),
  .re_n(nand_re_n), .cmd_lat(nand_cmd_lat), .addr_lat(nand_addr_lat),
  .dq_oe(nand_dq_oe), .rb(nand_rb), .dq_in(nand_dq_in),
  .rd_byte(rd_byte), .done(done), .phase(phase_q)
);

// File: tb/nand_strobe_gen_bench.sv
`timescale 1ns/1ps
module nand_strobe_gen_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [1:0]  req_kind = 2'd0;
  logic        req_last = 1'b0;
  logic [7:0]  req_byte = 8'h00;
  logic [25:0] timing_word = '0;
  logic [7:0]  nand_dq_in = 8'h00;
  logic        nand_rb = 1'b1;
  logic        nand_ce_n, nand_we_n, nand_re_n, nand_cmd_lat, nand_addr_lat;
  logic        nand_dq_oe, done;
  logic [7:0]  nand_dq_out, rd_byte;

  int checks = 0;
  int errors = 0;
  bit prev_read = 0;
  bit timed_out = 0;

  always #4 clk = ~clk;

  nand_strobe_gen u_nand_strobe_gen (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
    .req_last(req_last), .req_byte(req_byte), .timing_word(timing_word),
    .nand_ce_n(nand_ce_n), .nand_we_n(nand_we_n), .nand_re_n(nand_re_n),
    .nand_cmd_lat(nand_cmd_lat), .nand_addr_lat(nand_addr_lat),
    .nand_dq_oe(nand_dq_oe), .nand_dq_out(nand_dq_out), .nand_dq_in(nand_dq_in),
    .nand_rb(nand_rb), .rd_byte(rd_byte), .done(done)
  );

  function automatic int ln(int v);
    return (v == 0) ? 1 : v;
  endfunction

  function automatic logic [25:0] mk(int cea, int bsy, int ta, int rh, int rl, int wh, int wl);
    return {cea[1:0], bsy[4:0], ta[2:0], rh[3:0], rl[3:0], wh[3:0], wl[3:0]};
  endfunction

  task automatic chk(string tag, logic [6:0] got, logic [6:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: {ce_n,we_n,re_n,cmd,addr,oe,done} actual %b expected %b", tag, got, exp);
    end
  endtask

  task automatic chk8(string tag, logic [7:0] got, logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: byte actual %h expected %h", tag, got, exp);
    end
  endtask

  // Drive one request from a negedge and follow it to its done cycle.
  // rb_delay < 0 keeps nand_rb high the whole time (R8 ignore check).
  task automatic run_req(int kind, logic [7:0] b, bit last, logic [25:0] tw,
                         int rb_delay, bit stray, logic [7:0] rdata);
    bit rd, waiting;
    int s, t, l, h, bd, p, tot, rb_hi, lo0, acc_end;
    logic [6:0] exp;
    string tag;
    rd      = (kind == 3);
    waiting = !rd && last;
    s  = ln(int'(tw[25:24]));
    t  = (!rd && prev_read) ? ln(int'(tw[18:16])) : 0;
    l  = rd ? ln(int'(tw[11:8]))  : ln(int'(tw[3:0]));
    h  = rd ? ln(int'(tw[15:12])) : ln(int'(tw[7:4]));
    bd = waiting ? ln(int'(tw[23:19])) : 0;
    lo0 = s + t;
    acc_end = s + t + l + h;
    p = acc_end + bd;
    rb_hi = (rb_delay < 0) ? 0 : p + rb_delay;
    tot = p + (waiting ? ((rb_delay < 0) ? 1 : rb_delay + 1) : 0);
    req_valid = 1'b1; req_kind = kind[1:0]; req_byte = b;
    req_last = last; timing_word = tw;
    nand_rb = (waiting && rb_delay >= 0) ? 1'b0 : 1'b1;
    nand_dq_in = ~rdata;
    for (int i = 0; i <= tot; i++) begin
      @(negedge clk);
      if (i == 0) req_valid = 1'b0;
      if (stray && i == 1) begin        // R9: ignored while busy
        req_valid = 1'b1; req_kind = 2'd3 - kind[1:0]; req_byte = ~b;
        req_last = ~last; timing_word = ~tw;
      end
      if (stray && i == 2) req_valid = 1'b0;
      nand_rb    = (!waiting || i >= rb_hi) ? 1'b1 : 1'b0;
      nand_dq_in = (rd && i >= lo0 && i < lo0 + l) ? rdata : ~rdata;
      if (i == tot) begin
        exp = 7'b1110001; tag = "R9";
      end else begin
        exp[6] = 1'b0;
        exp[5] = !(!rd && i >= lo0 && i < lo0 + l);
        exp[4] = !(rd && i >= lo0 && i < lo0 + l);
        exp[3] = (kind == 0) && i < acc_end;
        exp[2] = (kind == 1) && i < acc_end;
        exp[1] = !rd && i >= lo0 && i < acc_end;
        exp[0] = 1'b0;
        if (i < s)            tag = "R2";
        else if (i < lo0)     tag = "R7";
        else if (i < acc_end) tag = (kind < 2) ? "R10" : (rd ? "R4" : "R3");
        else                  tag = "R8";
      end
      chk(tag, {nand_ce_n, nand_we_n, nand_re_n, nand_cmd_lat, nand_addr_lat,
                nand_dq_oe, done}, exp);
      if (exp[1]) chk8("R3", nand_dq_out, b);
    end
    if (rd) chk8("R6", rd_byte, rdata);
    prev_read = rd;
  endtask

  task automatic run_all;
    logic [7:0] held;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R1: idle levels after reset
    chk("R1", {nand_ce_n, nand_we_n, nand_re_n, nand_cmd_lat, nand_addr_lat,
               nand_dq_oe, done}, 7'b1110000);
    run_req(0, 8'h70, 0, mk(2, 3, 4, 1, 2, 3, 2), 0, 0, 8'h00);      // R10 command
    run_req(1, 8'h12, 0, mk(1, 3, 4, 1, 2, 1, 3), 0, 0, 8'h00);      // R10 address
    run_req(3, 8'h00, 0, mk(3, 3, 4, 2, 3, 1, 1), 0, 0, 8'hA5);      // R4 R6 read
    run_req(2, 8'h3C, 0, mk(1, 3, 4, 1, 1, 2, 2), 0, 0, 8'h00);      // R7 turnaround
    run_req(0, 8'h10, 1, mk(1, 5, 2, 1, 1, 1, 1), 3, 0, 8'h00);      // R8 busy wait
    run_req(0, 8'h10, 1, mk(2, 6, 2, 1, 1, 2, 1), -1, 0, 8'h00);     // R8 rb high early
    run_req(3, 8'h00, 0, 26'd0, 0, 0, 8'h5A);                        // R5 all zero read
    run_req(2, 8'hC3, 0, 26'd0, 0, 0, 8'h00);                        // R5 zero turnaround
    run_req(2, 8'h99, 0, mk(2, 1, 1, 1, 1, 4, 3), 0, 1, 8'h00);      // R9 stray
    run_req(3, 8'h00, 0, mk(1, 1, 7, 4, 2, 1, 1), 0, 1, 8'h81);      // R9 stray on read
    run_req(3, 8'h00, 0, mk(0, 1, 7, 1, 15, 1, 1), 0, 0, 8'h7E);     // R4 back to back reads
    run_req(2, 8'hF0, 1, mk(3, 31, 7, 15, 15, 15, 15), 0, 0, 8'h00); // R3 R7 R8 maxima
    held = rd_byte;
    run_req(1, 8'h44, 0, mk(1, 1, 1, 1, 1, 1, 1), 0, 0, 8'h00);
    chk8("R6", rd_byte, held);  // R6: write leaves the read holding register
  endtask

  initial begin
    fork
      run_all();
      begin
        repeat (100000) @(posedge clk);
        timed_out = 1;
      end
    join_any
    disable fork;
    if (timed_out) begin
      checks++; errors++;
      $display("FAIL R9: watchdog, actual no completion expected done pulse");
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule